// File: doc/BRIEF.md
# Serial Converter Conversion Sequencer

This block is the host-side master for a serial 8-bit analog-to-digital converter with a four-channel input selector. A single-cycle request, together with a 4-bit channel word, starts one conversion frame. The sequencer lowers the converter's select line and waits a setup interval. It then toggles the serial clock and presents a leading one followed by the channel word, most significant bit first. After that it gives one spare clock for input settling and collects the 8 result bits, most significant first.

When the replay check is enabled, the frame runs seven more clock pulses. The converter sends the result again least significant first, and these seven bits are compared with the first capture. A disagreement raises a flag. At the end of the frame the select line returns high and the result appears with a one-cycle completion strobe. The data driver turns off once addressing is finished, so the host data-in and data-out pins can share one wire. The serial clock rate comes from a parameter that sets the number of system clocks in each half period.

Top module: `adc_serial_host`

## Requirements
- R1: After reset the select line `cs_n_o` is high, `sclk_o` is low, and `done_o`, `busy_o`, `di_oe_o` and `mismatch_o` are all 0.
- R2: On rising serial clock edges 1 to 5 of a frame, `di_o` carries 1, then `chan_i[3]`, `chan_i[2]`, `chan_i[1]`, `chan_i[0]`, with the channel word latched when the request is accepted.
- R3: Every high and every low half of the serial clock inside a frame lasts exactly DIV_HALF system clock cycles.
- R4: `cs_n_o` falls DIV_HALF cycles before the first rising serial clock edge and stays low until the last pulse of the frame has ended.
- R5: `di_oe_o` is 1 from the accepted request until the fifth pulse's falling edge and 0 at every later rising edge of the frame.
- R6: After the five address pulses and one spare pulse, the next 8 pulses each deliver one result bit, first bit is bit 7. The value of `do_i` is taken at the end of each low half, and the 8 bits appear on `result_o`.
- R7: With `lsb_check_i` = 1 at the request, the frame has 21 pulses, and the last 7 pulses carry result bits 1 to 7 in that order. `mismatch_o` is 1 when any of them differs from the first capture. With `lsb_check_i` = 0 the frame has 14 pulses and `mismatch_o` is 0.
- R8: `done_o` is a one-cycle pulse issued in the cycle that `cs_n_o` rises. `result_o` and `mismatch_o` change only in that cycle.
- R9: Between frames `cs_n_o` stays high for at least 2*DIV_HALF cycles. A request made while `busy_o` is 1 is ignored and does not start a later frame.
- R10: `sclk_o` is low whenever `cs_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled while idle |
| chan_i | input | 4 | Channel assignment word sent after the leading one |
| lsb_check_i | input | 1 | Enables capture and comparison of the reversed replay |
| busy_o | output | 1 | Frame or inter-frame gap in progress |
| cs_n_o | output | 1 | Converter select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| di_o | output | 1 | Serial data toward the converter |
| di_oe_o | output | 1 | Drive enable for `di_o`, for a shared data wire |
| do_i | input | 1 | Serial data from the converter |
| result_o | output | 8 | Last conversion result |
| mismatch_o | output | 1 | Replay disagreed with first capture |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The hardest case to reach is a replay that disagrees with the first capture. A correct converter never produces one, so the mismatch path only runs if the converter model is told to invert one chosen bit of the reversed stream. The bench moves that corrupted position at random over all seven replay slots and also targets the first and last slots directly. It additionally corrupts frames with the check turned off, where the flag must stay low. A second case that is hard to reach is a request arriving mid-frame. The bench makes one at random points with a different channel word, then checks that the received address and the idle line afterwards show no trace of it.

// File: rtl/adc_host_pkg.sv
`timescale 1ns/1ps
package adc_host_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/adc_half_timer.sv
`timescale 1ns/1ps
module adc_half_timer #(
    parameter int DIV_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV_HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end
endmodule

// File: rtl/adc_rx_capture.sv
`timescale 1ns/1ps
module adc_rx_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              do_i,
    input  logic              take_msb_i,
    input  logic              take_lsb_i,
    output logic [DATA_W-1:0] msb_next_o,
    output logic              replay_bad_next_o
);
    logic [1:0]        sync_d, sync_q;
    logic [DATA_W-1:0] msb_d, msb_q;
    logic [DATA_W-2:0] lsb_d, lsb_q;

    always_comb begin
        sync_d = {sync_q[0], do_i};
        msb_d  = msb_q;
        lsb_d  = lsb_q;
        if (clear_i) begin
            msb_d = '0;
            lsb_d = '0;
        end else begin
            if (take_msb_i) begin
                msb_d = {msb_q[DATA_W-2:0], sync_q[1]};
            end
            if (take_lsb_i) begin
                lsb_d = {sync_q[1], lsb_q[DATA_W-2:1]};
            end
        end
        msb_next_o        = msb_d;
        replay_bad_next_o = (lsb_d != msb_d[DATA_W-1:1]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            msb_q  <= '0;
            lsb_q  <= '0;
        end else begin
            sync_q <= sync_d;
            msb_q  <= msb_d;
            lsb_q  <= lsb_d;
        end
    end
endmodule

// File: rtl/adc_serial_host.sv
`timescale 1ns/1ps
module adc_serial_host #(
    parameter int DIV_HALF = 4,
    parameter int WORD_W   = 4,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [WORD_W-1:0] chan_i,
    input  logic              lsb_check_i,
    output logic              busy_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              di_o,
    output logic              di_oe_o,
    input  logic              do_i,
    output logic [DATA_W-1:0] result_o,
    output logic              mismatch_o,
    output logic              done_o
);
    import adc_host_pkg::*;

    // pulse indices, counted from 0
    localparam int FIRST_DATA = WORD_W + 2;
    localparam int LAST_MSB   = FIRST_DATA + DATA_W - 1;
    localparam int LAST_LSB   = LAST_MSB + DATA_W - 1;
    localparam int PW         = $clog2(LAST_LSB + 1);

    typedef struct packed {
        seq_state_e        state;
        logic [PW-1:0]     pulse;
        logic [WORD_W-1:0] word;
        logic              lsb_en;
        logic              gap;
        logic              cs_n;
        logic              sclk;
        logic              di;
        logic              oe;
        logic [DATA_W-1:0] result;
        logic              mismatch;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic              tick;
    logic              run;
    logic              take_msb;
    logic              take_lsb;
    logic              clear;
    logic [DATA_W-1:0] msb_next;
    logic              replay_bad_next;
    logic [PW-1:0]     last_pulse;

    assign run = (r_q.state != ST_IDLE);

    adc_half_timer #(.DIV_HALF(DIV_HALF)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    adc_rx_capture #(.DATA_W(DATA_W)) u_capture (
        .clk               (clk),
        .rst_n             (rst_n),
        .clear_i           (clear),
        .do_i              (do_i),
        .take_msb_i        (take_msb),
        .take_lsb_i        (take_lsb),
        .msb_next_o        (msb_next),
        .replay_bad_next_o (replay_bad_next)
    );

    always_comb begin
        last_pulse = r_q.lsb_en ? PW'(LAST_LSB) : PW'(LAST_MSB);
        clear      = (r_q.state == ST_IDLE) && start_i;
        take_msb   = (r_q.state == ST_LOW) && tick &&
                     (r_q.pulse >= PW'(FIRST_DATA)) && (r_q.pulse <= PW'(LAST_MSB));
        take_lsb   = (r_q.state == ST_LOW) && tick && r_q.lsb_en &&
                     (r_q.pulse > PW'(LAST_MSB)) && (r_q.pulse <= PW'(LAST_LSB));

        r_d      = r_q;
        r_d.done = 1'b0;

        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state  = ST_LEAD;
                    r_d.pulse  = '0;
                    r_d.word   = chan_i;
                    r_d.lsb_en = lsb_check_i;
                    r_d.cs_n   = 1'b0;
                    r_d.sclk   = 1'b0;
                    r_d.di     = 1'b1;
                    r_d.oe     = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    r_d.state = ST_HIGH;
                    r_d.sclk  = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    r_d.state = ST_LOW;
                    r_d.sclk  = 1'b0;
                    if (r_q.pulse < PW'(WORD_W)) begin
                        r_d.di   = r_q.word[WORD_W-1];
                        r_d.word = r_q.word << 1;
                    end else begin
                        r_d.di = 1'b0;
                        r_d.oe = 1'b0;
                    end
                end
            end
            ST_LOW: begin
                if (tick) begin
                    if (r_q.pulse == last_pulse) begin
                        r_d.state    = ST_GAP;
                        r_d.gap      = 1'b0;
                        r_d.cs_n     = 1'b1;
                        r_d.done     = 1'b1;
                        r_d.result   = msb_next;
                        r_d.mismatch = r_q.lsb_en && replay_bad_next;
                    end else begin
                        r_d.state = ST_HIGH;
                        r_d.sclk  = 1'b1;
                        r_d.pulse = r_q.pulse + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (r_q.gap) begin
                        r_d.state = ST_IDLE;
                    end else begin
                        r_d.gap = 1'b1;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
            r_q.cs_n     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o     = run;
    assign cs_n_o     = r_q.cs_n;
    assign sclk_o     = r_q.sclk;
    assign di_o       = r_q.di;
    assign di_oe_o    = r_q.oe;
    assign result_o   = r_q.result;
    assign mismatch_o = r_q.mismatch;
    assign done_o     = r_q.done;
endmodule

// File: rtl/adc_serial_host_checker.sv
`timescale 1ns/1ps
module adc_serial_host_checker #(
    parameter int DIV_HALF = 4,
    parameter int DATA_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              di_oe_o,
    input logic              done_o,
    input logic              busy_o,
    input logic [DATA_W-1:0] result_o,
    input logic              mismatch_o
);
    localparam int LIMIT = 2 * DIV_HALF;
    localparam int CW    = $clog2(LIMIT + 1) + 1;
    localparam logic [CW-1:0] SAT = CW'(LIMIT);

    logic [CW-1:0] hi_q, lo_q, csh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q  <= '0;
            lo_q  <= '0;
            csh_q <= SAT;
        end else begin
            hi_q  <= !sclk_o ? '0 : (hi_q == SAT ? hi_q : hi_q + 1'b1);
            lo_q  <= (sclk_o || cs_n_o) ? '0 : (lo_q == SAT ? lo_q : lo_q + 1'b1);
            csh_q <= !cs_n_o ? '0 : (csh_q == SAT ? csh_q : csh_q + 1'b1);
        end
    end

    assert_high_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk_o) |-> hi_q == CW'(DIV_HALF));

    assert_low_half_R3_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> lo_q == CW'(DIV_HALF));

    assert_drive_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        di_oe_o |-> !cs_n_o);

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_with_cs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $fell(busy_o) == 1'b0 && !$past(cs_n_o)));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(($stable(result_o)) && $stable(mismatch_o)) |-> done_o);

    assert_cs_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> csh_q >= SAT);

    assert_clock_parked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sclk_o);
endmodule

bind adc_serial_host adc_serial_host_checker #(
    .DIV_HALF (DIV_HALF),
    .DATA_W   (DATA_W)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_o     (cs_n_o),
    .sclk_o     (sclk_o),
    .di_oe_o    (di_oe_o),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .result_o   (result_o),
    .mismatch_o (mismatch_o)
);

// File: tb/adc_serial_host_test.sv
`timescale 1ns/1ps
module adc_serial_host_test;
    localparam int DIV_HALF = 4;
    localparam int WORD_W   = 4;
    localparam int DATA_W   = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [WORD_W-1:0] chan_i = '0;
    logic              lsb_check_i = 1'b0;
    logic              busy_o, cs_n_o, sclk_o, di_o, di_oe_o;
    logic              do_i = 1'b0;
    logic [DATA_W-1:0] result_o;
    logic              mismatch_o, done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // converter model state
    int         rise_n = 0;
    int         fall_n = 0;
    int         frame_pulses = 0;
    logic [4:0] rx_addr = '0;
    bit         oe_late = 0;
    logic [7:0] m_code = '0;
    bit         m_corrupt = 0;
    int         m_bad_fall = 0;

    always #2.5 clk = ~clk;

    adc_serial_host #(.DIV_HALF(DIV_HALF), .WORD_W(WORD_W), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .lsb_check_i(lsb_check_i), .busy_o(busy_o), .cs_n_o(cs_n_o),
        .sclk_o(sclk_o), .di_o(di_o), .di_oe_o(di_oe_o), .do_i(do_i),
        .result_o(result_o), .mismatch_o(mismatch_o), .done_o(done_o)
    );

    function automatic logic model_bit(input int f);
        logic b;
        b = 1'b0;
        if (f >= 7 && f <= 14) b = m_code[14 - f];
        else if (f >= 15 && f <= 21) b = m_code[f - 14] ^ (m_corrupt && f == m_bad_fall);
        return b;
    endfunction

    always @(posedge sclk_o or negedge sclk_o or posedge cs_n_o) begin
        if (cs_n_o) begin
            frame_pulses = rise_n;
            rise_n = 0;
            fall_n = 0;
            do_i = 1'b0;
        end else if (sclk_o) begin
            rise_n = rise_n + 1;
            if (rise_n <= 5) rx_addr = {rx_addr[3:0], di_o};
            else if (di_oe_o) oe_late = 1;
        end else begin
            fall_n = fall_n + 1;
            do_i = model_bit(fall_n);
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(n < 2000, "R8 completion timeout", n, 2000);
    endtask

    task automatic convert(input logic [3:0] ch, input logic [7:0] code, input bit lsb,
                           input bit corrupt, input int bad_fall, input bit poke);
        bit exp_mis;
        int expp;
        m_code = code; m_corrupt = corrupt; m_bad_fall = bad_fall;
        rx_addr = '0; oe_late = 0;
        @(negedge clk);
        chan_i = ch; lsb_check_i = lsb; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!cs_n_o && busy_o, "R4 select low after request", cs_n_o, 0);
        if (poke) begin
            repeat (20 + ($urandom % 60)) @(negedge clk);
            chan_i = ~ch; lsb_check_i = ~lsb; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_done();
        exp_mis = lsb && corrupt;
        expp = lsb ? 21 : 14;
        check(result_o == code, "R6 result", result_o, code);
        check(mismatch_o == exp_mis, "R7 mismatch flag", mismatch_o, exp_mis);
        check(frame_pulses == expp, "R7 pulse count", frame_pulses, expp);
        check(rx_addr == {1'b1, ch}, "R2 address bits", rx_addr, {1'b1, ch});
        check(!oe_late, "R5 driver released", oe_late, 0);
        check(cs_n_o && !sclk_o, "R10 select high clock low at done", cs_n_o, 1);
        @(negedge clk);
        check(!done_o, "R8 done single cycle", done_o, 0);
        check(result_o == code, "R8 result held", result_o, code);
        repeat (2 * DIV_HALF + 2) @(negedge clk);
        check(cs_n_o && !busy_o, "R9 no frame from ignored request", busy_o, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int gap;
        void'($urandom(32'h0a1c_0833));
        repeat (3) @(negedge clk);
        check(cs_n_o && !sclk_o && !done_o && !busy_o && !di_oe_o && !mismatch_o,
              "R1 reset state", {cs_n_o, sclk_o, done_o, busy_o, di_oe_o, mismatch_o}, 6'b100000);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o && !busy_o, "R1 idle after reset", busy_o, 0);

        // directed corners
        convert(4'h0, 8'h00, 1'b0, 1'b0, 0, 1'b0);
        convert(4'hF, 8'hFF, 1'b1, 1'b0, 0, 1'b0);
        convert(4'hA, 8'h5A, 1'b1, 1'b1, 15, 1'b0);
        convert(4'h5, 8'hA5, 1'b1, 1'b1, 21, 1'b0);
        convert(4'h3, 8'h81, 1'b0, 1'b1, 18, 1'b1);

        // back-to-back requests: select must stay high between frames (R9)
        m_corrupt = 0; m_code = 8'h3C;
        @(negedge clk);
        chan_i = 4'h6; lsb_check_i = 1'b0; start_i = 1'b1;
        wait_done();
        gap = 0;
        while (cs_n_o && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        check(gap >= 2 * DIV_HALF, "R9 select high gap", gap, 2 * DIV_HALF);
        start_i = 1'b0;
        wait_done();
        check(result_o == 8'h3C, "R6 back-to-back result", result_o, 8'h3C);
        repeat (2 * DIV_HALF + 2) @(negedge clk);

        // random frames
        for (int i = 0; i < 30; i++) begin
            logic [3:0] ch;
            logic [7:0] cd;
            bit lb, cr, pk;
            int bf;
            ch = 4'($urandom);
            cd = 8'($urandom);
            lb = 1'($urandom);
            cr = ($urandom % 2) == 0;
            bf = 15 + int'($urandom % 7);
            pk = ($urandom % 4) == 0;
            convert(ch, cd, lb, cr, bf, pk);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule